// File: doc/BRIEF.md
# Test Output Multiplexer With Bypass

This block picks which internal node of a clock synthesizer appears on a single-ended test pin. A 3-bit test code chooses among eight sources: the serial configuration shift-register output, two constant levels, the reference clock, the output of the programmable feedback counter, the divided main output, that output further divided by four, and a bypass mode. While the parallel-load input is low, the registered test code is held at zero, so the test pin shows the shift-register output.

The block owns the 9-bit feedback (M) counter. In normal operation the counter advances on rising edges of the loop (VCO-side) clock. In bypass mode the serial clock pin replaces the loop clock as the edge source for both the M counter and the output divider, so the whole divider chain can be stepped slowly from a board tester. The output divider itself sits outside the block; it receives `div_tick`, one pulse per rising edge of whichever source is selected. Both clock inputs are sampled in the fast core clock domain, and source changes pass through a short parked interval so that no partial edge reaches the dividers.

The source selector is a four-state machine. `SRC_LOOP` forwards loop-clock edges. A request for bypass moves it to `SRC_TO_SER`, where no edges are forwarded for `PARK_CYC` cycles. It then enters `SRC_SER`, which forwards serial-clock edges. Leaving bypass moves it through `SRC_TO_LOOP` (parked for `PARK_CYC` cycles) back to `SRC_LOOP`. A request that reverses while parked returns at once to the state that was just left.

Top module: `tm_top`

## Requirements
- R1: While `rst_n` is low, the test code register is 000, `test_out` equals `sr_out`, and `mcnt_pulse` and `div_tick` are low.
- R2: With test code 001 the test pin is constant 1; with test code 101 it is constant 0, whatever `sr_out` is.
- R3: Test code 000 routes `sr_out`, 010 routes `ref_clk`, 100 routes `fout_div` and 111 routes `fout_div4` to `test_out`, one core clock after the code is sampled.
- R4: While `pload` is low, the registered code is forced to 000 whatever `test_code` is. The first core clock edge with `pload` high loads `test_code`.
- R5: Under test code 011, `test_out` carries the M counter pulse. Its rising edges are spaced by exactly `m_val` rising edges of `vco_clk`, and activity on `ser_clk` has no effect.
- R6: Under test code 110 (bypass), `test_out` carries the M counter pulse counted on `ser_clk`. Its rising edges are spaced by exactly `m_val` serial-clock edges, and activity on `vco_clk` has no effect.
- R7: Once the selector has settled, `div_tick` gives one single-cycle pulse per rising edge of the selected source: `ser_clk` under code 110, `vco_clk` under every other code.
- R8: The M counter pulse is not a half-duty clock. It stays high for exactly one period of the selected source and changes only on a `div_tick`.
- R9: From the cycle in which the registered code enters or leaves 110, `div_tick` stays low for `PARK_CYC`+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pload | input | 1 | Parallel-load level; low holds the test code at 000 |
| test_code | input | 3 | Test source select from the serial configuration |
| m_val | input | 9 | Feedback counter modulus |
| ref_clk | input | 1 | Reference clock, routed under code 010 |
| vco_clk | input | 1 | Loop clock, sampled and edge-detected |
| ser_clk | input | 1 | Serial clock pin, sampled and edge-detected |
| fout_div | input | 1 | Divided main output |
| fout_div4 | input | 1 | Divided main output divided by four |
| sr_out | input | 1 | Serial-out bit of the configuration shift register |
| test_out | output | 1 | Test pin |
| div_tick | output | 1 | One pulse per edge of the selected divider clock source |
| mcnt_pulse | output | 1 | Terminal pulse of the M counter |

## Verification
The static codes are tried with their routed input at both levels while the other inputs hold the opposite value, so a wrong mux leg shows up as a wrong level. The counter modes run with both clock sources toggling at different rates (loop clock period 4, serial clock period 8). Because of this, the pulse spacing and pulse width show which source is being counted as well as the modulus, and two M values are used in each mode. The handoff is checked with both sources running across a switch in each direction, so a missing park interval would show up as an early tick.

// File: rtl/tm_pkg.sv
package tm_pkg;
    typedef enum logic [2:0] {
        TC_SHIFT  = 3'b000,
        TC_HIGH   = 3'b001,
        TC_REF    = 3'b010,
        TC_MCNT   = 3'b011,
        TC_FOUT   = 3'b100,
        TC_LOW    = 3'b101,
        TC_BYPASS = 3'b110,
        TC_FOUT_Q = 3'b111
    } tcode_t;

    typedef enum logic [1:0] {
        SRC_LOOP,
        SRC_TO_SER,
        SRC_SER,
        SRC_TO_LOOP
    } src_st_t;
endpackage

// File: rtl/tm_edge.sv
module tm_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], din};
    end

    // sh[STAGES-1] is the synchronised level, sh[STAGES] its previous value
    assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/tm_src_fsm.sv
module tm_src_fsm
    import tm_pkg::*;
#(
    parameter int PARK_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want_ser,
    input  logic loop_rise,
    input  logic ser_rise,
    output logic tick
);
    localparam int PK_W = $clog2(PARK_CYC + 1);

    src_st_t          st, nxt;
    logic [PK_W-1:0]  pk;
    logic             park_done;

    assign park_done = (pk == PK_W'(PARK_CYC - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= SRC_LOOP;
            pk <= '0;
        end else begin
            st <= nxt;
            if (st != nxt) pk <= '0;
            else if (st == SRC_TO_SER || st == SRC_TO_LOOP) pk <= pk + 1'b1;
        end
    end

    always_comb begin
        nxt = st;
        unique case (st)
            SRC_LOOP:    if (want_ser)   nxt = SRC_TO_SER;
            SRC_TO_SER:  if (!want_ser)  nxt = SRC_LOOP;
                         else if (park_done) nxt = SRC_SER;
            SRC_SER:     if (!want_ser)  nxt = SRC_TO_LOOP;
            SRC_TO_LOOP: if (want_ser)   nxt = SRC_SER;
                         else if (park_done) nxt = SRC_LOOP;
        endcase
    end

    // outputs: edges pass only when the settled state agrees with the request
    always_comb begin
        tick = 1'b0;
        unique case (st)
            SRC_LOOP:    tick = loop_rise & ~want_ser;
            SRC_SER:     tick = ser_rise & want_ser;
            SRC_TO_SER,
            SRC_TO_LOOP: tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/tm_mcnt.sv
module tm_mcnt #(
    parameter int M_W = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic [M_W-1:0] m_val,
    output logic           pulse
);
    logic [M_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            pulse <= 1'b0;
        end else if (tick) begin
            if (cnt == '0) begin
                cnt   <= m_val - 1'b1;
                pulse <= 1'b1;
            end else begin
                cnt   <= cnt - 1'b1;
                pulse <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tm_top.sv
module tm_top
    import tm_pkg::*;
#(
    parameter int M_W         = 9,
    parameter int SYNC_STAGES = 2,
    parameter int PARK_CYC    = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pload,
    input  logic [2:0]     test_code,
    input  logic [M_W-1:0] m_val,
    input  logic           ref_clk,
    input  logic           vco_clk,
    input  logic           ser_clk,
    input  logic           fout_div,
    input  logic           fout_div4,
    input  logic           sr_out,
    output logic           test_out,
    output logic           div_tick,
    output logic           mcnt_pulse
);
    tcode_t code_q;
    logic   loop_rise, ser_rise, want_ser;

    // test-select register, held at 000 while the parallel load is low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      code_q <= TC_SHIFT;
        else if (!pload) code_q <= TC_SHIFT;
        else             code_q <= tcode_t'(test_code);
    end

    assign want_ser = (code_q == TC_BYPASS);

    tm_edge #(.STAGES(SYNC_STAGES)) loop_edge_i (
        .clk(clk), .rst_n(rst_n), .din(vco_clk), .rise(loop_rise));
    tm_edge #(.STAGES(SYNC_STAGES)) ser_edge_i (
        .clk(clk), .rst_n(rst_n), .din(ser_clk), .rise(ser_rise));

    tm_src_fsm #(.PARK_CYC(PARK_CYC)) src_i (
        .clk(clk), .rst_n(rst_n), .want_ser(want_ser),
        .loop_rise(loop_rise), .ser_rise(ser_rise), .tick(div_tick));

    tm_mcnt #(.M_W(M_W)) mcnt_i (
        .clk(clk), .rst_n(rst_n), .tick(div_tick), .m_val(m_val),
        .pulse(mcnt_pulse));

    always_comb begin
        test_out = 1'b0;
        unique case (code_q)
            TC_SHIFT:  test_out = sr_out;
            TC_HIGH:   test_out = 1'b1;
            TC_REF:    test_out = ref_clk;
            TC_MCNT:   test_out = mcnt_pulse;
            TC_FOUT:   test_out = fout_div;
            TC_LOW:    test_out = 1'b0;
            TC_BYPASS: test_out = mcnt_pulse;
            TC_FOUT_Q: test_out = fout_div4;
        endcase
    end
endmodule

// File: rtl/tm_chk.sv
module tm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pload,
    input logic [2:0] code_q,
    input logic       div_tick,
    input logic       loop_rise,
    input logic       ser_rise,
    input logic       mcnt_pulse
);
    AST_PLOAD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !pload |=> (code_q == 3'b000));                                   // R4

    AST_PULSE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mcnt_pulse) |-> $past(div_tick));                          // R5

    AST_TICK_HAS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        div_tick |-> (loop_rise || ser_rise));                            // R7

    AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !div_tick |=> $stable(mcnt_pulse));                               // R8

    AST_SWITCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((code_q == 3'b110) != $past(code_q == 3'b110)) |-> !div_tick);  // R9
endmodule

bind tm_top tm_chk chk_i (
    .clk(clk), .rst_n(rst_n), .pload(pload), .code_q(code_q),
    .div_tick(div_tick), .loop_rise(loop_rise), .ser_rise(ser_rise),
    .mcnt_pulse(mcnt_pulse));

// File: tb/tm_top_tb.sv
module tm_top_tb_top;
    localparam int PARK    = 4;
    localparam int VCO_PER = 4;
    localparam int SER_PER = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pload = 1'b1;
    logic [2:0] test_code = 3'b000;
    logic [8:0] m_val = 9'd7;
    logic       ref_clk = 1'b0, fout_div = 1'b0, fout_div4 = 1'b0, sr_out = 1'b0;
    logic       vco_clk, ser_clk;
    logic       test_out, div_tick, mcnt_pulse;
    logic       vco_en = 1'b1, ser_en = 1'b1;
    int         vco_ph = 0, ser_ph = 0;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    int    exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    always @(negedge clk) begin
        vco_ph <= (vco_ph + 1) % VCO_PER;
        ser_ph <= (ser_ph + 1) % SER_PER;
    end
    assign vco_clk = vco_en && (vco_ph < VCO_PER/2);
    assign ser_clk = ser_en && (ser_ph < SER_PER/2);

    tm_top dut_i (
        .clk(clk), .rst_n(rst_n), .pload(pload), .test_code(test_code),
        .m_val(m_val), .ref_clk(ref_clk), .vco_clk(vco_clk), .ser_clk(ser_clk),
        .fout_div(fout_div), .fout_div4(fout_div4), .sr_out(sr_out),
        .test_out(test_out), .div_tick(div_tick), .mcnt_pulse(mcnt_pulse));

    // driver side: push what the requirement predicts
    task automatic push_exp(string tag, int v);
        tag_q.push_back(tag);
        exp_q.push_back(v);
    endtask

    // monitor side: pop the oldest prediction and compare
    task automatic pop_cmp(int act);
        string tag;
        int    e;
        tag = tag_q.pop_front();
        e   = exp_q.pop_front();
        n_cmp++;
        if (act != e) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, e);
        end
    endtask

    task automatic samp;
        @(posedge clk); #2;
    endtask

    task automatic set_code(logic [2:0] c);
        @(negedge clk); test_code = c;
    endtask

    // cycles between rises of test_out and the high width of the pulse
    task automatic measure(output int spacing, output int width);
        logic prev;
        int   c;
        spacing = -1; width = -1; c = 0;
        samp; prev = test_out;
        while (!(test_out && !prev) && c < 3000) begin prev = test_out; samp; c++; end
        c = 0; width = 0;
        while (test_out && c < 3000) begin samp; width++; c++; end
        spacing = width;
        while (!test_out && c < 3000) begin samp; spacing++; c++; end
    endtask

    task automatic count_ticks(int win, output int n);
        n = 0;
        for (int i = 0; i < win; i++) begin samp; if (div_tick) n++; end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #3000000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int sp, wd, nt, quiet;
        // R1: reset state, code 001 requested but register held at 000
        test_code = 3'b001; sr_out = 1'b0;
        repeat (3) samp;
        push_exp("R1", 0); pop_cmp(test_out);
        push_exp("R1", 0); pop_cmp({30'd0, mcnt_pulse} | {30'd0, div_tick});
        @(negedge clk); sr_out = 1'b1;
        samp; push_exp("R1", 1); pop_cmp(test_out);
        @(negedge clk); rst_n = 1'b1; sr_out = 1'b0;

        // R2: constant levels
        samp; push_exp("R2", 1); pop_cmp(test_out);
        set_code(3'b101); @(negedge clk); sr_out = 1'b1;
        samp; push_exp("R2", 0); pop_cmp(test_out);

        // R3: routed sources
        set_code(3'b000); samp; push_exp("R3", 1); pop_cmp(test_out);
        @(negedge clk); sr_out = 1'b0; samp; push_exp("R3", 0); pop_cmp(test_out);
        set_code(3'b010); @(negedge clk); ref_clk = 1'b1; sr_out = 1'b1;
        samp; push_exp("R3", 1); pop_cmp(test_out);
        @(negedge clk); ref_clk = 1'b0; samp; push_exp("R3", 0); pop_cmp(test_out);
        set_code(3'b100); @(negedge clk); fout_div = 1'b1; fout_div4 = 1'b0;
        samp; push_exp("R3", 1); pop_cmp(test_out);
        set_code(3'b111); samp; push_exp("R3", 0); pop_cmp(test_out);
        @(negedge clk); fout_div4 = 1'b1; fout_div = 1'b0;
        samp; push_exp("R3", 1); pop_cmp(test_out);

        // R4: parallel load low forces code 000
        @(negedge clk); pload = 1'b0; test_code = 3'b001; sr_out = 1'b0;
        samp; push_exp("R4", 0); pop_cmp(test_out);
        @(negedge clk); sr_out = 1'b1; samp; push_exp("R4", 1); pop_cmp(test_out);
        @(negedge clk); sr_out = 1'b0; pload = 1'b1;
        samp; push_exp("R4", 1); pop_cmp(test_out);

        // R5, R8: loop clock counting, serial clock also toggling
        @(negedge clk); m_val = 9'd7; test_code = 3'b011;
        measure(sp, wd); measure(sp, wd);
        push_exp("R5", 7*VCO_PER); pop_cmp(sp);
        push_exp("R8", VCO_PER);   pop_cmp(wd);
        @(negedge clk); m_val = 9'd5;
        measure(sp, wd); measure(sp, wd); measure(sp, wd);
        push_exp("R5", 5*VCO_PER); pop_cmp(sp);

        // R7: ticks follow the loop clock
        count_ticks(80, nt); push_exp("R7", 80/VCO_PER); pop_cmp(nt);

        // R9: switch into bypass, quiet window
        set_code(3'b110);
        quiet = 0;
        for (int i = 0; i < PARK + 1; i++) begin samp; if (div_tick) quiet++; end
        push_exp("R9", 0); pop_cmp(quiet);

        // R6, R8: serial clock counting, loop clock still toggling
        measure(sp, wd); measure(sp, wd); measure(sp, wd);
        push_exp("R6", 5*SER_PER); pop_cmp(sp);
        push_exp("R8", SER_PER);   pop_cmp(wd);
        @(negedge clk); m_val = 9'd9;
        measure(sp, wd); measure(sp, wd); measure(sp, wd);
        push_exp("R6", 9*SER_PER); pop_cmp(sp);

        // R7: ticks follow the serial clock
        count_ticks(80, nt); push_exp("R7", 80/SER_PER); pop_cmp(nt);
        // R6: loop clock stopped changes nothing
        @(negedge clk); vco_en = 1'b0;
        count_ticks(80, nt); push_exp("R6", 80/SER_PER); pop_cmp(nt);
        @(negedge clk); vco_en = 1'b1;

        // R9: switch back to the loop clock
        set_code(3'b011);
        quiet = 0;
        for (int i = 0; i < PARK + 1; i++) begin samp; if (div_tick) quiet++; end
        push_exp("R9", 0); pop_cmp(quiet);
        // R5: serial clock stopped, loop counting unaffected
        @(negedge clk); ser_en = 1'b0; m_val = 9'd6;
        measure(sp, wd); measure(sp, wd); measure(sp, wd);
        push_exp("R5", 6*VCO_PER); pop_cmp(sp);

        finish_run();
    end
endmodule